// File: doc/BRIEF.md
# Dual-Accumulator Integer Multiply-Accumulate Unit

This block is the fixed-point multiplier stage of a signal-processing datapath. Each cycle it may take one operation: an opcode, two 32-bit operands, a signedness choice and the index of one of two 80-bit accumulators. It can form a product, add it to or subtract it from the chosen accumulator, clamp or round that accumulator, load it from an operand, or read it out. Every operation sends its value either back into the accumulator or out as a 32-bit result word.

Instruction decode and the register file are outside the block. The surrounding pipeline presents decoded fields on the inputs with `valid_i` high. It collects the result word on the cycle after the operation, when `res_valid_o` is high. Two status flags report the sign of the value just produced and whether a 32-bit result overflowed.

Top module: `mac_unit`

## Requirements
- R1: After a synchronous active-low reset, `res_o`, `res_valid_o`, `flag_mn_o` and `flag_mv_o` are 0 and both accumulators hold 0.
- R2: Opcode 1 places the low 32 bits of `rx_i*ry_i` on `res_o` one clock after the operation is accepted, and pulses `res_valid_o` for that clock.
- R3: Opcode 2 writes the full product into the selected accumulator. Opcode 11 loads that accumulator with `rx_i`, sign-extended in signed mode and zero-extended in unsigned mode.
- R4: Opcode 3 adds the product to the selected accumulator and opcode 4 subtracts it, both in 80-bit two's-complement arithmetic.
- R5: Opcodes 5 and 6 form accumulator plus or minus product and emit its low 32 bits on `res_o`. Opcode 12 emits the accumulator's low 32 bits. No result-destination opcode changes any accumulator.
- R6: Only the accumulator named by `acc_sel_i` (0 or 1) can change. The other keeps its value.
- R7: Saturate clamps the accumulator to the 32-bit range of the chosen signedness: [-2^31, 2^31-1] in signed mode, [0, 2^32-1] in unsigned mode. The accumulator is read as signed 80-bit. Opcode 7 writes the clamped value back and opcode 8 sends it to `res_o`.
- R8: Round adds 2^31 to the accumulator and discards the low 32 bits. Opcode 9 writes the value back with bits 31:0 cleared. Opcode 10 sends the rounded value shifted right arithmetically by 32 to `res_o`.
- R9: `signed_i`=1 treats both operands as two's complement and `signed_i`=0 treats both as unsigned.
- R10: `flag_mn_o` equals bit 79 of the full 80-bit value produced by the operation. For example, -2*3 signed gives 1.
- R11: `flag_mv_o` is 1 only for a result-destination opcode whose full value lies outside the 32-bit range of the chosen signedness. It is 0 after any accumulator-destination opcode.
- R12: With `valid_i` low, or with opcode 0 or 13..15, the outputs, flags and accumulators keep their values and `res_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Opcode (0 idle, 1..12 as in the requirements) |
| acc_sel_i | input | 1 | Accumulator index |
| signed_i | input | 1 | 1 = signed operands, 0 = unsigned |
| rx_i | input | 32 | First operand |
| ry_i | input | 32 | Second operand |
| res_o | output | 32 | Result word |
| res_valid_o | output | 1 | `res_o` updated this cycle |
| flag_mn_o | output | 1 | Negative flag of the last operation |
| flag_mv_o | output | 1 | 32-bit overflow flag of the last operation |

## Verification
The assertions assume that an opcode or select value arriving with `valid_i` low carries no meaning. The bench therefore drives random opcodes and selects during idle cycles, so the hold property is exercised against arbitrary input values. They also assume that `acc_sel_i` names an existing accumulator, which the one-bit select guarantees at the default size. Random operands are drawn partly from small magnitudes and range edges, so that repeated accumulation, saturation and overflow at the 32-bit boundaries happen often rather than by chance.

// File: rtl/mac_pkg.sv
// Shared opcode encoding of the multiply-accumulate unit.
// Assumes a 4-bit opcode field; codes 13..15 act as idle.
package mac_pkg;
    typedef enum logic [3:0] {
        OP_IDLE    = 4'd0,
        OP_MUL_RES = 4'd1,
        OP_MUL_ACC = 4'd2,
        OP_ADD_ACC = 4'd3,
        OP_SUB_ACC = 4'd4,
        OP_ADD_RES = 4'd5,
        OP_SUB_RES = 4'd6,
        OP_SAT_ACC = 4'd7,
        OP_SAT_RES = 4'd8,
        OP_RND_ACC = 4'd9,
        OP_RND_RES = 4'd10,
        OP_LOAD    = 4'd11,
        OP_READ    = 4'd12
    } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
// Operand multiplier. Extends both operands by one bit (sign or zero,
// per the signedness input) and forms a signed product. The product is
// sign-extended to the accumulator width.
// Assumes ACC_W > 2*OP_W + 2.
module mac_mult #(
    parameter int OP_W  = 32,
    parameter int ACC_W = 80
) (
    input  logic [OP_W-1:0]  rx_i,
    input  logic [OP_W-1:0]  ry_i,
    input  logic             signed_i,
    output logic [ACC_W-1:0] prod_o
);
    localparam int PW  = 2*OP_W + 2;
    localparam int EXT = ACC_W - PW;

    logic signed [OP_W:0] xa;
    logic signed [OP_W:0] ya;
    logic signed [PW-1:0] p;

    // extend operands and multiply as signed values
    always_comb begin
        xa = {signed_i & rx_i[OP_W-1], rx_i};
        ya = {signed_i & ry_i[OP_W-1], ry_i};
        p  = PW'(xa) * PW'(ya);
        prod_o = {{EXT{p[PW-1]}}, p};
    end
endmodule

// File: rtl/mac_datapath.sv
// Value generator. Given the opcode, the selected accumulator, the
// product and the first operand, it forms the full-width value of the
// operation and says where that value goes (accumulator or result word).
// Assumes accumulator contents are signed two's-complement.
module mac_datapath
    import mac_pkg::*;
#(
    parameter int OP_W  = 32,
    parameter int ACC_W = 80
) (
    input  logic [3:0]       op_i,
    input  logic             signed_i,
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ACC_W-1:0] prod_i,
    input  logic [OP_W-1:0]  rx_i,
    output logic [ACC_W-1:0] val_o,
    output logic             to_acc_o,
    output logic             to_res_o
);
    localparam int HI_W = ACC_W - OP_W;
    localparam logic [ACC_W-1:0] SMAX = {{(HI_W+1){1'b0}}, {(OP_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] SMIN = {{(HI_W+1){1'b1}}, {(OP_W-1){1'b0}}};
    localparam logic [ACC_W-1:0] UMAX = {{HI_W{1'b0}}, {OP_W{1'b1}}};

    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] dif;
    logic [ACC_W-1:0] sat;
    logic [ACC_W-1:0] ld;
    logic [HI_W-1:0]  rnd_hi;
    logic             fit_s;
    logic             fit_u;

    // arithmetic with the product
    always_comb begin
        sum = acc_i + prod_i;
        dif = acc_i - prod_i;
    end

    // clamp to the 32-bit range of the chosen signedness
    always_comb begin
        fit_s = (&acc_i[ACC_W-1:OP_W-1]) | ~(|acc_i[ACC_W-1:OP_W-1]);
        fit_u = ~(|acc_i[ACC_W-1:OP_W]);
        if (signed_i) begin
            if (fit_s)                sat = acc_i;
            else if (acc_i[ACC_W-1])  sat = SMIN;
            else                      sat = SMAX;
        end else begin
            if (fit_u)                sat = acc_i;
            else if (acc_i[ACC_W-1])  sat = '0;
            else                      sat = UMAX;
        end
    end

    // round: the half-LSB add only carries into the upper part when bit OP_W-1 is set
    always_comb begin
        rnd_hi = acc_i[ACC_W-1:OP_W] + HI_W'(acc_i[OP_W-1]);
    end

    // direct load with sign or zero extension
    always_comb begin
        ld = {{HI_W{signed_i & rx_i[OP_W-1]}}, rx_i};
    end

    // choose the value and its destination
    always_comb begin
        val_o    = '0;
        to_acc_o = 1'b0;
        to_res_o = 1'b0;
        case (mac_op_e'(op_i))
            OP_MUL_RES: begin val_o = prod_i; to_res_o = 1'b1; end
            OP_MUL_ACC: begin val_o = prod_i; to_acc_o = 1'b1; end
            OP_ADD_ACC: begin val_o = sum;    to_acc_o = 1'b1; end
            OP_SUB_ACC: begin val_o = dif;    to_acc_o = 1'b1; end
            OP_ADD_RES: begin val_o = sum;    to_res_o = 1'b1; end
            OP_SUB_RES: begin val_o = dif;    to_res_o = 1'b1; end
            OP_SAT_ACC: begin val_o = sat;    to_acc_o = 1'b1; end
            OP_SAT_RES: begin val_o = sat;    to_res_o = 1'b1; end
            OP_RND_ACC: begin val_o = {rnd_hi, {OP_W{1'b0}}}; to_acc_o = 1'b1; end
            OP_RND_RES: begin val_o = {{OP_W{rnd_hi[HI_W-1]}}, rnd_hi}; to_res_o = 1'b1; end
            OP_LOAD:    begin val_o = ld;     to_acc_o = 1'b1; end
            OP_READ:    begin val_o = acc_i;  to_res_o = 1'b1; end
            default:    begin val_o = '0; end
        endcase
    end
endmodule

// File: rtl/mac_flags.sv
// Status flag logic. Negative is the top bit of the full value. Overflow
// is raised only for a result-word destination whose value falls outside
// the OP_W-bit range of the chosen signedness.
// Assumes hi_i carries bits ACC_W-1 down to OP_W-1 of the value.
module mac_flags #(
    parameter int OP_W  = 32,
    parameter int ACC_W = 80
) (
    input  logic [ACC_W-OP_W:0] hi_i,
    input  logic                signed_i,
    input  logic                to_res_i,
    output logic                mn_o,
    output logic                mv_o
);
    localparam int TOP = ACC_W - OP_W;

    logic fit_s;
    logic fit_u;

    // range test and flag forming
    always_comb begin
        fit_s = (&hi_i) | ~(|hi_i);
        fit_u = ~(|hi_i[TOP:1]);
        mn_o  = hi_i[TOP];
        mv_o  = to_res_i & ~(signed_i ? fit_s : fit_u);
    end
endmodule

// File: rtl/mac_acc_bank.sv
// Bank of N_ACC accumulator registers with one write port and one read
// port, both addressed by the same select. All bank contents are also
// exposed flat for observation.
// Assumes N_ACC >= 2 and sel_i below N_ACC.
module mac_acc_bank #(
    parameter int ACC_W = 80,
    parameter int N_ACC = 2,
    localparam int SEL_W = $clog2(N_ACC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [SEL_W-1:0]       sel_i,
    input  logic [ACC_W-1:0]       wr_data_i,
    output logic [ACC_W-1:0]       rd_data_o,
    output logic [N_ACC*ACC_W-1:0] acc_all_o
);
    logic [ACC_W-1:0] acc_q [N_ACC];

    for (genvar k = 0; k < N_ACC; k++) begin : g_acc
        // write one accumulator when it is addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                acc_q[k] <= '0;
            else if (wr_en_i && (sel_i == SEL_W'(k)))
                acc_q[k] <= wr_data_i;
        end
        assign acc_all_o[k*ACC_W +: ACC_W] = acc_q[k];
    end

    // read port
    assign rd_data_o = acc_q[sel_i];
endmodule

// File: rtl/mac_unit.sv
// Dual-accumulator multiply-accumulate unit, top level. Takes one operation
// per cycle while valid_i is high. The result word, its valid strobe and
// the flags are registered, so they appear one clock after the operation.
// Accumulator writes land on the same edge.
// Assumes acc_sel_i is below N_ACC.
module mac_unit
    import mac_pkg::*;
#(
    parameter int OP_W  = 32,
    parameter int ACC_W = 80,
    parameter int N_ACC = 2,
    localparam int SEL_W = $clog2(N_ACC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [3:0]       op_i,
    input  logic [SEL_W-1:0] acc_sel_i,
    input  logic             signed_i,
    input  logic [OP_W-1:0]  rx_i,
    input  logic [OP_W-1:0]  ry_i,
    output logic [OP_W-1:0]  res_o,
    output logic             res_valid_o,
    output logic             flag_mn_o,
    output logic             flag_mv_o
);
    logic [ACC_W-1:0]       prod;
    logic [ACC_W-1:0]       acc_cur;
    logic [ACC_W-1:0]       val;
    logic [N_ACC*ACC_W-1:0] acc_all;
    logic                   to_acc;
    logic                   to_res;
    logic                   mn;
    logic                   mv;
    logic [OP_W-1:0]        res_q;
    logic                   vld_q;
    logic                   mn_q;
    logic                   mv_q;

    mac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) i_mult (
        .rx_i     (rx_i),
        .ry_i     (ry_i),
        .signed_i (signed_i),
        .prod_o   (prod)
    );

    mac_acc_bank #(.ACC_W(ACC_W), .N_ACC(N_ACC)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (valid_i & to_acc),
        .sel_i     (acc_sel_i),
        .wr_data_i (val),
        .rd_data_o (acc_cur),
        .acc_all_o (acc_all)
    );

    mac_datapath #(.OP_W(OP_W), .ACC_W(ACC_W)) i_dp (
        .op_i     (op_i),
        .signed_i (signed_i),
        .acc_i    (acc_cur),
        .prod_i   (prod),
        .rx_i     (rx_i),
        .val_o    (val),
        .to_acc_o (to_acc),
        .to_res_o (to_res)
    );

    mac_flags #(.OP_W(OP_W), .ACC_W(ACC_W)) i_flags (
        .hi_i     (val[ACC_W-1:OP_W-1]),
        .signed_i (signed_i),
        .to_res_i (to_res),
        .mn_o     (mn),
        .mv_o     (mv)
    );

    // register result word, strobe and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            vld_q <= 1'b0;
            mn_q  <= 1'b0;
            mv_q  <= 1'b0;
        end else begin
            vld_q <= valid_i & to_res;
            if (valid_i && (to_res || to_acc)) begin
                mn_q <= mn;
                mv_q <= mv;
            end
            if (valid_i && to_res)
                res_q <= val[OP_W-1:0];
        end
    end

    assign res_o       = res_q;
    assign res_valid_o = vld_q;
    assign flag_mn_o   = mn_q;
    assign flag_mv_o   = mv_q;
endmodule

// File: rtl/mac_unit_chk.sv
// Property checker for mac_unit, attached by bind. Watches the ports and
// the flat accumulator vector of the bank.
// Assumes N_ACC >= 2.
module mac_unit_chk
    import mac_pkg::*;
#(
    parameter int OP_W  = 32,
    parameter int ACC_W = 80,
    parameter int N_ACC = 2,
    localparam int SEL_W = $clog2(N_ACC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   valid_i,
    input  logic [3:0]             op_i,
    input  logic [SEL_W-1:0]       acc_sel_i,
    input  logic                   signed_i,
    input  logic [OP_W-1:0]        res_o,
    input  logic                   res_valid_o,
    input  logic                   flag_mn_o,
    input  logic                   flag_mv_o,
    input  logic [N_ACC*ACC_W-1:0] acc_all
);
    logic [SEL_W-1:0] last_sel;
    logic [ACC_W-1:0] sel_acc;
    logic             res_op;
    logic             acc_op;

    // remember which accumulator the previous cycle named
    always_ff @(posedge clk) last_sel <= acc_sel_i;

    // accumulator named in the previous cycle, and opcode classes
    always_comb begin
        sel_acc = acc_all[last_sel*ACC_W +: ACC_W];
        res_op  = (op_i == OP_MUL_RES) || (op_i == OP_ADD_RES) || (op_i == OP_SUB_RES) ||
                  (op_i == OP_SAT_RES) || (op_i == OP_RND_RES) || (op_i == OP_READ);
        acc_op  = (op_i == OP_MUL_ACC) || (op_i == OP_ADD_ACC) || (op_i == OP_SUB_ACC) ||
                  (op_i == OP_SAT_ACC) || (op_i == OP_RND_ACC) || (op_i == OP_LOAD);
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(res_o) && $stable(flag_mn_o) && $stable(flag_mv_o) && !res_valid_o && $stable(acc_all)); // R12

    AST_STROBE_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $past(valid_i)); // R2

    AST_RES_OP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && res_op |=> $stable(acc_all)); // R5

    AST_SAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && (op_i == OP_SAT_ACC) && signed_i |=>
            ((&sel_acc[ACC_W-1:OP_W-1]) || !(|sel_acc[ACC_W-1:OP_W-1]))); // R7

    AST_RND_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && (op_i == OP_RND_ACC) |=> (sel_acc[OP_W-1:0] == '0)); // R8

    AST_NO_MV_ON_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && acc_op |=> !flag_mv_o); // R11

    for (genvar k = 0; k < N_ACC; k++) begin : g_other
        AST_OTHER_ACC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            valid_i && (acc_sel_i != SEL_W'(k)) |=> $stable(acc_all[k*ACC_W +: ACC_W])); // R6
    end
endmodule

bind mac_unit mac_unit_chk #(.OP_W(OP_W), .ACC_W(ACC_W), .N_ACC(N_ACC)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .op_i        (op_i),
    .acc_sel_i   (acc_sel_i),
    .signed_i    (signed_i),
    .res_o       (res_o),
    .res_valid_o (res_valid_o),
    .flag_mn_o   (flag_mn_o),
    .flag_mv_o   (flag_mv_o),
    .acc_all     (acc_all)
);

// File: tb/test_mac_unit.sv
`timescale 1ns/1ps
module test_mac_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [3:0]  op = '0;
    logic        sel = 1'b0;
    logic        sgn = 1'b0;
    logic [31:0] rx = '0;
    logic [31:0] ry = '0;
    logic [31:0] res;
    logic        res_vld;
    logic        mn;
    logic        mv;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic signed [79:0] m_acc [2];
    logic [31:0]        e_res;
    logic               e_mn;
    logic               e_mv;

    always #2.5 clk = ~clk;

    mac_unit i_mac_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid), .op_i(op), .acc_sel_i(sel),
        .signed_i(sgn), .rx_i(rx), .ry_i(ry), .res_o(res), .res_valid_o(res_vld),
        .flag_mn_o(mn), .flag_mv_o(mv)
    );

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic signed [79:0] ext(input logic [31:0] a, input logic s);
        return s ? {{48{a[31]}}, a} : {48'd0, a};
    endfunction

    function automatic logic signed [79:0] product(input logic [31:0] a, input logic [31:0] b, input logic s);
        return ext(a, s) * ext(b, s);
    endfunction

    function automatic bit fits(input logic signed [79:0] v, input logic s);
        if (s) return (v >= -80'sd2147483648) && (v <= 80'sd2147483647);
        return (v >= 0) && (v <= 80'sd4294967295);
    endfunction

    function automatic logic signed [79:0] clamp(input logic signed [79:0] v, input logic s);
        if (s) begin
            if (v > 80'sd2147483647)  return 80'sd2147483647;
            if (v < -80'sd2147483648) return -80'sd2147483648;
            return v;
        end
        if (v < 0) return 0;
        if (v > 80'sd4294967295) return 80'sd4294967295;
        return v;
    endfunction

    function automatic logic signed [79:0] round_it(input logic signed [79:0] v);
        logic signed [79:0] r;
        r = v + 80'sd2147483648;
        r[31:0] = '0;
        return r;
    endfunction

    // one operation: model update, drive at a falling edge, check at the next
    task automatic run_op(input logic [3:0] o, input logic s_acc, input logic s,
                          input logic [31:0] a, input logic [31:0] b, input string req);
        logic signed [79:0] cur, p, v, rr;
        bit to_res, to_acc;
        cur = m_acc[s_acc];
        p = product(a, b, s);
        to_res = 0; to_acc = 0; v = '0;
        case (o)
            4'd1:  begin v = p;                    to_res = 1; end
            4'd2:  begin v = p;                    to_acc = 1; end
            4'd3:  begin v = cur + p;              to_acc = 1; end
            4'd4:  begin v = cur - p;              to_acc = 1; end
            4'd5:  begin v = cur + p;              to_res = 1; end
            4'd6:  begin v = cur - p;              to_res = 1; end
            4'd7:  begin v = clamp(cur, s);        to_acc = 1; end
            4'd8:  begin v = clamp(cur, s);        to_res = 1; end
            4'd9:  begin v = round_it(cur);        to_acc = 1; end
            4'd10: begin rr = round_it(cur); v = rr >>> 32; to_res = 1; end
            4'd11: begin v = ext(a, s);            to_acc = 1; end
            4'd12: begin v = cur;                  to_res = 1; end
            default: ;
        endcase
        if (to_acc) m_acc[s_acc] = v;
        if (to_acc || to_res) begin
            e_mn = v[79];
            e_mv = to_res && !fits(v, s);
        end
        if (to_res) e_res = v[31:0];
        @(negedge clk);
        valid = 1'b1; op = o; sel = s_acc; sgn = s; rx = a; ry = b;
        @(negedge clk);
        chk({req, " R2/R5 strobe"}, 80'(res_vld), 80'(to_res));
        chk({req, " result"}, 80'(res), 80'(e_res));
        chk({req, " R10 mn"}, 80'(mn), 80'(e_mn));
        chk({req, " R11 mv"}, 80'(mv), 80'(e_mv));
        valid = 1'b0;
        op = 4'($urandom_range(0, 15)); sel = 1'($urandom); rx = $urandom; ry = $urandom;
    endtask

    // read an accumulator's low word and check it against the model (R5 / R6)
    task automatic read_acc(input logic s_acc, input string req);
        run_op(4'd12, s_acc, 1'b1, '0, '0, req);
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 5))
            0: return 32'h8000_0000;
            1: return 32'h7FFF_FFFF;
            2: return 32'hFFFF_FFFF;
            3: return 32'($urandom_range(0, 20)) - 32'd10;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd4242));
        m_acc[0] = '0; m_acc[1] = '0;
        e_res = '0; e_mn = 0; e_mv = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 res", 80'(res), 80'd0);
        chk("R1 strobe", 80'(res_vld), 80'd0);
        chk("R1 mn", 80'(mn), 80'd0);
        chk("R1 mv", 80'(mv), 80'd0);
        rst_n = 1'b1;
        read_acc(1'b0, "R1 acc0 zero");
        read_acc(1'b1, "R1 acc1 zero");

        // R2 R10 R9: -2*3 signed is negative, no overflow
        run_op(4'd1, 0, 1, 32'hFFFF_FFFE, 32'd3, "R2 R10 R9 signed product");
        chk("R10 mn after -2*3", 80'(mn), 80'd1);
        // R9 R11 unsigned product overflow
        run_op(4'd1, 0, 0, 32'hFFFF_FFFF, 32'd2, "R9 R11 unsigned product");
        chk("R11 mv unsigned overflow", 80'(mv), 80'd1);
        // R3 load and R7 saturate in signed mode
        run_op(4'd11, 0, 1, 32'h8000_0000, '0, "R3 signed load");
        run_op(4'd4, 0, 1, 32'd5, 32'd1, "R4 subtract below range");
        run_op(4'd8, 0, 1, '0, '0, "R7 saturate to result");
        chk("R7 signed min", 80'(res), 80'h8000_0000);
        run_op(4'd7, 0, 0, '0, '0, "R7 unsigned saturate of negative");
        read_acc(1'b0, "R7 acc0 is zero");
        chk("R7 clamped to zero", 80'(res), 80'd0);
        // R8 round: 2^31 rounds up to 1
        run_op(4'd2, 1, 0, 32'h0001_0000, 32'h0000_8000, "R3 product to acc1");
        run_op(4'd10, 1, 1, '0, '0, "R8 round to result");
        chk("R8 rounded value", 80'(res), 80'd1);
        run_op(4'd9, 1, 1, '0, '0, "R8 round in place");
        read_acc(1'b1, "R8 low word cleared");
        // R6 other accumulator untouched
        run_op(4'd3, 0, 1, 32'd7, 32'd9, "R4 R6 add on acc0");
        read_acc(1'b1, "R6 acc1 unchanged");
        // R5 result op leaves accumulator
        run_op(4'd6, 0, 1, 32'd100, 32'd100, "R5 subtract to result");
        read_acc(1'b0, "R5 acc0 unchanged");
        // R12 idle opcodes with valid high
        run_op(4'd0, 0, 1, 32'd3, 32'd3, "R12 opcode 0");
        run_op(4'd14, 1, 0, 32'd3, 32'd3, "R12 opcode 14");
        read_acc(1'b0, "R12 acc0 after idle codes");
        // R12 valid low holds everything
        @(negedge clk);
        chk("R12 hold res", 80'(res), 80'(e_res));
        chk("R12 hold strobe", 80'(res_vld), 80'd0);

        for (int i = 0; i < 600; i++) begin
            run_op(4'($urandom_range(0, 15)), 1'($urandom), 1'($urandom), pick(), pick(), "R4 R9 random");
            if ($urandom_range(0, 7) == 0) read_acc(1'($urandom), "R6 random read");
        end
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog R12 actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule